// File: doc/BRIEF.md
# Serial Configuration Stream Header Parser

This block sits beside a one-bit serial configuration input and follows the stream as it arrives. It takes one bit on each clock where the valid strobe is high. It waits through a run of ones that precedes the stream, recognises a short start pattern and loads a 24-bit length count. It then checks a run of trailer ones and counts the payload bits until the whole stream has arrived. The outputs give the loaded length, a flag for a good header, a single-cycle completion pulse, and separate error flags for a bad trailer and for a stream whose length does not agree with the loaded count.

The length count is always seven less than the number of bits in the stream. The final seven bits belong to the check of the last frame and must still arrive after the count itself is reached. The parser counts every accepted bit from the first one of the leading run. It signals completion when that count equals the loaded length plus seven. When the strobe stays low for a set number of cycles before completion, the stream is treated as cut short.

Top module: `cfg_stream_hdr_parser`

## Requirements
- R1: A bit is accepted only on a clock where `bit_vld` is 1. On any other clock `bit_in` is ignored and `len_o` holds its value.
- R2: While hunting, the parser counts a run of accepted ones. A 0 that arrives after at least 8 ones ends the fill and is the first start-pattern bit. A 0 that arrives after fewer than 8 ones empties the run. The stream bit count starts at the first one of the run that leads to the start pattern.
- R3: The start pattern is 0010 in arrival order. If a later bit of the pattern is wrong, the parser returns to hunting, discards that bit and clears the count.
- R4: The 24 bits after the start pattern form the length, most significant bit first, so the first of them lands in bit 23 of `len_o`. `len_o` changes only during those 24 accepted bits.
- R5: Four trailer bits of value 1 follow the length. An accepted 0 among them sets `trl_err_o` on the next clock. The stream is abandoned and `hdr_ok_o` stays 0.
- R6: `hdr_ok_o` rises on the clock after the fourth trailer one and stays high until reset.
- R7: `done_o` is high for exactly one clock: the clock after the accepted bit that brings the stream bit count to the length plus 7.
- R8: If the count at the end of the trailer already exceeds the length plus 7, `len_err_o` is set on the next clock. If the count equals the length plus 7 at that point, `done_o` fires together with the rise of `hdr_ok_o`.
- R9: Between the end of the fill and completion, 16 consecutive clocks (parameter `IDLE_TMO`) with `bit_vld` low set `len_err_o`. A gap of 15 clocks does not.
- R10: After completion or after either error, further bits are ignored. The flags, `hdr_ok_o` and `len_o` hold, and `done_o` does not fire again.
- R11: A synchronous reset returns the parser to hunting and clears the count, `len_o` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Serial stream bit |
| len_o | output | 24 | Length count, loaded most significant bit first |
| hdr_ok_o | output | 1 | Header fully received with a good trailer |
| done_o | output | 1 | One-clock pulse when the stream is complete |
| trl_err_o | output | 1 | Trailer contained a zero |
| len_err_o | output | 1 | Stream length disagrees with the count, or the stream stalled |

## Verification
The bench targets the seven-bit offset directly. A parser that finished at the raw count would pulse `done_o` seven bits early. A fill run cut short by a zero must restart the count, because a design that kept the old ones would also finish early. A broken start pattern must fall back to hunting, and a design that did not would accept a stream built on the wrong header. The bench also drives a length small enough that completion falls exactly on the last trailer bit, and one small enough that it falls before it. It drives idle gaps of one cycle under the timeout and of exactly the timeout. It toggles `bit_in` while the strobe is low, which exposes a design that samples unqualified bits.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [2:0] {
        ST_HUNT = 3'd0,
        ST_PRE  = 3'd1,
        ST_LEN  = 3'd2,
        ST_TRL  = 3'd3,
        ST_BODY = 3'd4,
        ST_FIN  = 3'd5,
        ST_ERR  = 3'd6
    } cfgp_state_e;

endpackage

// File: rtl/cfgp_field_shift.sv
module cfgp_field_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] value
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (shift_en) begin
            val_d = {val_q[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;

endmodule

// File: rtl/cfgp_idle_timer.sv
module cfgp_idle_timer #(
    parameter int TMO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic vld,
    output logic expired
);

    localparam int IW = $clog2(TMO + 1);

    logic [IW-1:0] idle_d, idle_q;

    always_comb begin
        expired = arm && !vld && (idle_q == IW'(TMO - 1));
        if (arm && !vld && !expired) begin
            idle_d = idle_q + 1'b1;
        end else begin
            idle_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_d;
        end
    end

endmodule

// File: rtl/cfgp_len_target.sv
module cfgp_len_target #(
    parameter int CNT_W      = 26,
    parameter int LEN_W      = 24,
    parameter int TAIL_EXTRA = 7
) (
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [LEN_W-1:0] len,
    output logic             at_end,
    output logic             beyond
);

    logic [CNT_W-1:0] target;

    always_comb begin
        target = {{(CNT_W - LEN_W){1'b0}}, len} + CNT_W'(TAIL_EXTRA);
        at_end = (cnt_next == target);
        beyond = (cnt_next > target);
    end

endmodule

// File: rtl/cfg_stream_hdr_parser.sv
module cfg_stream_hdr_parser
    import cfgp_pkg::*;
#(
    parameter int               LEN_W      = 24,
    parameter int               PRE_W      = 4,
    parameter logic [PRE_W-1:0] PRE_PAT    = 4'b0010,
    parameter int               TRL_W      = 4,
    parameter int               FILL_MIN   = 8,
    parameter int               TAIL_EXTRA = 7,
    parameter int               IDLE_TMO   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [LEN_W-1:0] len_o,
    output logic             hdr_ok_o,
    output logic             done_o,
    output logic             trl_err_o,
    output logic             len_err_o
);

    // Count must hold length + TAIL_EXTRA without wrapping.
    localparam int CNT_W   = LEN_W + 2;
    localparam int SUB_MAX = (LEN_W > PRE_W) ? ((LEN_W > TRL_W) ? LEN_W : TRL_W)
                                             : ((PRE_W > TRL_W) ? PRE_W : TRL_W);
    localparam int SUB_W   = $clog2(SUB_MAX + 1);

    typedef struct packed {
        cfgp_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic             hdr_ok;
        logic             done;
        logic             trl_err;
        logic             len_err;
    } regs_t;

    regs_t r_d, r_q;

    logic             len_shift;
    logic [LEN_W-1:0] len_val;
    logic             armed;
    logic             tmo_hit;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_end;
    logic             beyond;
    logic             fill_ok;
    logic [PRE_W-1:0] pre_sh;
    logic             pre_bit;

    assign len_shift = bit_vld && (r_q.st == ST_LEN);
    assign armed     = (r_q.st == ST_PRE) || (r_q.st == ST_LEN) ||
                       (r_q.st == ST_TRL) || (r_q.st == ST_BODY);
    assign cnt_inc   = (r_q.cnt == '1) ? r_q.cnt : r_q.cnt + 1'b1;
    assign fill_ok   = (r_q.cnt >= CNT_W'(FILL_MIN));
    assign pre_sh    = PRE_PAT << r_q.sub;
    assign pre_bit   = pre_sh[PRE_W-1];

    cfgp_field_shift #(.W(LEN_W)) u_len (
        .clk      (clk),
        .rst      (rst),
        .shift_en (len_shift),
        .bit_in   (bit_in),
        .value    (len_val)
    );

    cfgp_idle_timer #(.TMO(IDLE_TMO)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .arm     (armed),
        .vld     (bit_vld),
        .expired (tmo_hit)
    );

    cfgp_len_target #(
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .TAIL_EXTRA (TAIL_EXTRA)
    ) u_tgt (
        .cnt_next (cnt_inc),
        .len      (len_val),
        .at_end   (at_end),
        .beyond   (beyond)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (tmo_hit) begin
            r_d.len_err = 1'b1;
            r_d.st      = ST_ERR;
        end else if (bit_vld) begin
            unique case (r_q.st)
                ST_HUNT: begin
                    if (bit_in) begin
                        r_d.cnt = cnt_inc;
                    end else if (fill_ok) begin
                        // this zero is the first start-pattern bit
                        r_d.st  = ST_PRE;
                        r_d.sub = SUB_W'(1);
                        r_d.cnt = cnt_inc;
                    end else begin
                        r_d.cnt = '0;
                    end
                end
                ST_PRE: begin
                    if (bit_in == pre_bit) begin
                        r_d.cnt = cnt_inc;
                        if (r_q.sub == SUB_W'(PRE_W - 1)) begin
                            r_d.st  = ST_LEN;
                            r_d.sub = '0;
                        end else begin
                            r_d.sub = r_q.sub + 1'b1;
                        end
                    end else begin
                        r_d.st  = ST_HUNT;
                        r_d.cnt = '0;
                        r_d.sub = '0;
                    end
                end
                ST_LEN: begin
                    r_d.cnt = cnt_inc;
                    if (r_q.sub == SUB_W'(LEN_W - 1)) begin
                        r_d.st  = ST_TRL;
                        r_d.sub = '0;
                    end else begin
                        r_d.sub = r_q.sub + 1'b1;
                    end
                end
                ST_TRL: begin
                    if (!bit_in) begin
                        r_d.trl_err = 1'b1;
                        r_d.st      = ST_ERR;
                    end else begin
                        r_d.cnt = cnt_inc;
                        if (r_q.sub == SUB_W'(TRL_W - 1)) begin
                            r_d.hdr_ok = 1'b1;
                            r_d.sub    = '0;
                            if (at_end) begin
                                r_d.done = 1'b1;
                                r_d.st   = ST_FIN;
                            end else if (beyond) begin
                                r_d.len_err = 1'b1;
                                r_d.st      = ST_ERR;
                            end else begin
                                r_d.st = ST_BODY;
                            end
                        end else begin
                            r_d.sub = r_q.sub + 1'b1;
                        end
                    end
                end
                ST_BODY: begin
                    r_d.cnt = cnt_inc;
                    if (at_end) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_FIN;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_HUNT, cnt: '0, sub: '0, hdr_ok: 1'b0,
                     done: 1'b0, trl_err: 1'b0, len_err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign len_o     = len_val;
    assign hdr_ok_o  = r_q.hdr_ok;
    assign done_o    = r_q.done;
    assign trl_err_o = r_q.trl_err;
    assign len_err_o = r_q.len_err;

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_vld,
    input logic [LEN_W-1:0] len_o,
    input logic             hdr_ok_o,
    input logic             done_o,
    input logic             trl_err_o,
    input logic             len_err_o
);

    AST_LEN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(len_o)); // R1

    AST_LEN_FROZEN_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        hdr_ok_o |=> $stable(len_o)); // R4

    AST_TRL_ERR_NO_HDR: assert property (@(posedge clk) disable iff (rst)
        trl_err_o |-> !hdr_ok_o); // R5

    AST_HDR_STICKY: assert property (@(posedge clk) disable iff (rst)
        hdr_ok_o |=> hdr_ok_o); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_DONE_HAS_HDR: assert property (@(posedge clk) disable iff (rst)
        done_o |-> hdr_ok_o); // R8

    AST_TRL_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        trl_err_o |=> trl_err_o); // R10

    AST_LEN_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        len_err_o |=> len_err_o); // R10

    AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(trl_err_o || len_err_o)); // R10

    AST_ONE_ERR: assert property (@(posedge clk) disable iff (rst)
        !(trl_err_o && len_err_o)); // R10

endmodule

bind cfg_stream_hdr_parser cfgp_checker #(.LEN_W(LEN_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .len_o     (len_o),
    .hdr_ok_o  (hdr_ok_o),
    .done_o    (done_o),
    .trl_err_o (trl_err_o),
    .len_err_o (len_err_o)
);

// File: tb/test_cfg_stream_hdr_parser.sv
`timescale 1ns/1ps
module test_cfg_stream_hdr_parser;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic [23:0] len_o;
    logic        hdr_ok_o, done_o, trl_err_o, len_err_o;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_stream_hdr_parser i_cfg_stream_hdr_parser (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .len_o     (len_o),
        .hdr_ok_o  (hdr_ok_o),
        .done_o    (done_o),
        .trl_err_o (trl_err_o),
        .len_err_o (len_err_o)
    );

    // behavioural reference: 0 hunt, 1 start, 2 length, 3 trailer, 4 body, 5 end, 6 error
    int          m_st = 0, m_cnt = 0, m_sub = 0, m_idle = 0;
    logic [23:0] m_len = '0;
    bit          m_hdr = 0, m_done = 0, m_te = 0, m_le = 0;
    int          pre_pat[4] = '{0, 0, 1, 0};

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_sub = 0; m_idle = 0; m_len = '0;
            m_hdr = 0; m_done = 0; m_te = 0; m_le = 0;
        end else begin
            m_done = 0;
            if (m_st >= 1 && m_st <= 4 && !bit_vld) begin
                m_idle++;
                if (m_idle == TMO) begin
                    m_le = 1; m_st = 6;
                end
            end else begin
                m_idle = 0;
            end
            if (bit_vld) begin
                case (m_st)
                    0: if (bit_in) m_cnt++;
                       else if (m_cnt >= 8) begin m_st = 1; m_sub = 1; m_cnt++; end
                       else m_cnt = 0;
                    1: if (int'(bit_in) == pre_pat[m_sub]) begin
                           m_cnt++; m_sub++;
                           if (m_sub == 4) begin m_st = 2; m_sub = 0; end
                       end else begin
                           m_st = 0; m_cnt = 0; m_sub = 0;
                       end
                    2: begin
                           m_len = {m_len[22:0], bit_in};
                           m_cnt++; m_sub++;
                           if (m_sub == 24) begin m_st = 3; m_sub = 0; end
                       end
                    3: if (!bit_in) begin m_te = 1; m_st = 6; end
                       else begin
                           m_cnt++; m_sub++;
                           if (m_sub == 4) begin
                               m_hdr = 1;
                               if (m_cnt == int'(m_len) + 7) begin m_done = 1; m_st = 5; end
                               else if (m_cnt > int'(m_len) + 7) begin m_le = 1; m_st = 6; end
                               else m_st = 4;
                           end
                       end
                    4: begin
                           m_cnt++;
                           if (m_cnt == int'(m_len) + 7) begin m_done = 1; m_st = 5; end
                       end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk(len_o == m_len, "R4 len_o vs model", int'(len_o), int'(m_len));
            chk(hdr_ok_o == m_hdr, "R6 hdr_ok_o vs model", int'(hdr_ok_o), int'(m_hdr));
            chk(done_o == m_done, "R7 done_o vs model", int'(done_o), int'(m_done));
            chk(trl_err_o == m_te, "R5 trl_err_o vs model", int'(trl_err_o), int'(m_te));
            chk(len_err_o == m_le, "R9 len_err_o vs model", int'(len_err_o), int'(m_le));
            if (done_o) done_seen++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int gap_ctr = 0;

    task automatic send_bit(input logic b, input int gap);
        repeat (gap) begin
            @(negedge clk); bit_vld = 1'b0; bit_in = ~b;
        end
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); bit_vld = 1'b0; bit_in = ~bit_in;
        end
    endtask

    function automatic int gap_of(input bit gaps);
        gap_ctr++;
        return (gaps && (gap_ctr % 4 == 3)) ? 2 : 0;
    endfunction

    task automatic send_stream(input int nfill, input int len, input logic [3:0] trl,
                               input int nbody, input bit gaps);
        for (int i = 0; i < nfill; i++) send_bit(1'b1, gap_of(gaps));
        for (int i = 3; i >= 0; i--) send_bit(pre_pat[3-i] != 0, gap_of(gaps));
        for (int i = 23; i >= 0; i--) send_bit(len[i], gap_of(gaps));
        for (int i = 3; i >= 0; i--) send_bit(trl[i], gap_of(gaps));
        for (int i = 0; i < nbody; i++) send_bit((i % 3) == 0, gap_of(gaps));
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; bit_vld = 1'b0;
        @(negedge clk); rst = 1'b0;
        done_seen = 0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        chk(!hdr_ok_o && !done_o && !trl_err_o && !len_err_o && len_o == 0,
            "R11 outputs in reset", int'(len_o), 0);
        rst = 1'b0;

        // basic stream with strobe gaps and garbage on bit_in while idle
        send_stream(8, 53, 4'b1111, 20, 1'b1);
        idle(3);
        chk(done_seen == 1, "R7 one done pulse", done_seen, 1);
        chk(len_o == 24'd53, "R4 length loaded", int'(len_o), 53);
        chk(hdr_ok_o == 1'b1, "R6 hdr ok after trailer", int'(hdr_ok_o), 1);
        chk(!len_err_o && !trl_err_o, "R1 gaps cause no error", int'(len_err_o), 0);
        send_stream(8, 60, 4'b1111, 40, 1'b0);
        idle(2);
        chk(done_seen == 1 && len_o == 24'd53, "R10 bits after done ignored", int'(len_o), 53);

        // longer fill run
        do_reset();
        send_stream(13, 48, 4'b1111, 10, 1'b0);
        idle(2);
        chk(done_seen == 1, "R2 long fill counted", done_seen, 1);

        // short run then real stream
        do_reset();
        for (int i = 0; i < 5; i++) send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        send_stream(8, 38, 4'b1111, 5, 1'b0);
        idle(2);
        chk(done_seen == 1 && !len_err_o, "R2 short run resync", done_seen, 1);

        // broken start pattern
        do_reset();
        for (int i = 0; i < 9; i++) send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        send_bit(1'b1, 0);
        idle(TMO + 2);
        chk(len_err_o == 1'b0, "R3 mismatch back to hunt", int'(len_err_o), 0);
        send_stream(8, 37, 4'b1111, 4, 1'b0);
        idle(2);
        chk(done_seen == 1 && len_o == 24'd37, "R3 stream after resync", int'(len_o), 37);

        // trailer error
        do_reset();
        send_stream(8, 60, 4'b1011, 0, 1'b0);
        idle(2);
        chk(trl_err_o == 1'b1, "R5 trailer zero flagged", int'(trl_err_o), 1);
        chk(hdr_ok_o == 1'b0, "R5 no hdr ok", int'(hdr_ok_o), 0);
        for (int i = 0; i < 40; i++) send_bit(1'b1, 0);
        idle(TMO + 2);
        chk(done_seen == 0 && trl_err_o && !len_err_o, "R10 error state holds", done_seen, 0);

        // timeout
        do_reset();
        send_stream(8, 100, 4'b1111, 10, 1'b0);
        idle(TMO - 1);
        send_bit(1'b1, 0);
        idle(1);
        chk(len_err_o == 1'b0, "R9 gap one under limit", int'(len_err_o), 0);
        idle(TMO);
        chk(len_err_o == 1'b1, "R9 stall flagged", int'(len_err_o), 1);
        chk(done_seen == 0, "R9 no done after stall", done_seen, 0);

        // count already past target at trailer end
        do_reset();
        send_stream(8, 30, 4'b1111, 0, 1'b0);
        idle(2);
        chk(len_err_o == 1'b1, "R8 length too small", int'(len_err_o), 1);

        // count exactly at target at trailer end
        do_reset();
        send_stream(8, 33, 4'b1111, 0, 1'b0);
        idle(2);
        chk(done_seen == 1 && hdr_ok_o && !len_err_o, "R8 done at trailer end", done_seen, 1);

        // longer body
        do_reset();
        send_stream(8, 2993, 4'b1111, 2960, 1'b0);
        idle(2);
        chk(done_seen == 1 && len_o == 24'd2993, "R7 long stream done", int'(len_o), 2993);

        // reset mid body
        do_reset();
        send_stream(8, 500, 4'b1111, 20, 1'b0);
        @(negedge clk); rst = 1'b1; bit_vld = 1'b0;
        @(negedge clk); rst = 1'b0;
        chk(!hdr_ok_o && len_o == 0 && !len_err_o, "R11 reset mid stream", int'(len_o), 0);
        idle(TMO + 2);
        chk(len_err_o == 1'b0, "R11 back in hunt", int'(len_err_o), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule